// File: doc/BRIEF.md
# Complementary PWM Output Stage with Break Handling

This block sits at the end of a timer channel. It turns one raw PWM reference into a main output and a complementary output and holds both low for a programmable number of timer clocks around every change of the reference. Because of that gap, a power switch pair driven from the two outputs is never switched on at the same time. The counter that makes the reference is outside the block. The counter's overflow reaches the block as a one-cycle pulse.

An external break pin stops the outputs. The pin goes through a synchronizer, with selectable polarity and a separate enable. As soon as the first synchronizer stage sees the break, the global output-enable bit is cleared. Both outputs are then held low for the dead-time count, and after that they take their individually programmed idle levels. Each output's drive enable is either released or kept, as selected.

When the synchronized break arrives, a sticky status flag is set, and a level interrupt request follows it when allowed. Software and the automatic re-arm feature can raise output enable again only once the break input has gone away. The automatic re-arm acts on an overflow pulse. Software can clear the flag only under the same condition.

Top module: `pwm_brk_stage`

## Requirements
- R1: When output enable is 1 and `ref_i` changes, `out_comp` (on a rise) or `out_main` (on a fall) goes to 0 after the first clock edge that samples the change. The other output reaches its new level of 1 after edge number `dt_cnt`+1. A count of 0 gives a one-cycle latency.
- R2: While output enable is 1, `out_main` and `out_comp` are never both 1.
- R3: Break is active when `brk_en`=1 and `brk_i` equals `brk_pol`. It passes through two flops. Output enable reads 0 after the second clock edge that samples an active break. With `brk_en`=0 the pin has no effect.
- R4: On the edge where output enable drops, both outputs are held at 0 for `dt_cnt` cycles. After that they show `idle_main` and `idle_comp`.
- R5: Once the break has crossed both synchronizer stages, `brk_flag` reads 1 after the next edge and stays 1.
- R6: A `sw_flag_clr` pulse clears `brk_flag`. The pulse is ignored while either synchronizer stage holds an active break.
- R7: Output enable follows this priority, highest first: the first stage holds a break → 0; `sw_oe_set` → 1; `sw_oe_clr` → 0; `auto_oe` together with `ovf_i` → 1; otherwise it holds. So a set request is ignored during break.
- R8: With `auto_oe`=1, an `ovf_i` pulse sets output enable at that edge when no break and no clear request is present.
- R9: With output enable 1, `oen_main`=`ch_en` and `oen_comp`=`chn_en`. With output enable 0 and `keep_en`=0, both are 0. With output enable 0 and `keep_en`=1, both equal `ch_en` OR `chn_en`.
- R10: `irq` equals `brk_flag` AND `brk_ie` in every cycle.
- R11: After reset, output enable and `brk_flag` are 0, the outputs show the idle levels, and the reference register and both counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_i | input | 1 | Raw PWM reference |
| ovf_i | input | 1 | Counter overflow pulse |
| brk_i | input | 1 | Asynchronous break pin |
| brk_en | input | 1 | Break detection enable |
| brk_pol | input | 1 | Active level of the break pin |
| dt_cnt | input | 8 | Dead-time in timer clocks |
| idle_main | input | 1 | Idle level of the main output |
| idle_comp | input | 1 | Idle level of the complementary output |
| ch_en | input | 1 | Main channel enable |
| chn_en | input | 1 | Complementary channel enable |
| keep_en | input | 1 | 1 keeps drive enables while output enable is off |
| auto_oe | input | 1 | Re-arm output enable on overflow |
| brk_ie | input | 1 | Break interrupt enable |
| sw_oe_set | input | 1 | Software request to set output enable |
| sw_oe_clr | input | 1 | Software request to clear output enable |
| sw_flag_clr | input | 1 | Software write of 0 to the break flag |
| out_main | output | 1 | Main output level |
| out_comp | output | 1 | Complementary output level |
| oen_main | output | 1 | Main output drive enable |
| oen_comp | output | 1 | Complementary output drive enable |
| oe | output | 1 | Global output-enable state |
| brk_flag | output | 1 | Sticky break status |
| irq | output | 1 | Level interrupt request |

## Verification
Some properties are checked by assertions on every cycle. These are: no overlap of the two outputs while enabled, the low hold on entry to the off state, output enable being forced off by the first sync stage, the flag being set and kept while break persists, and the re-arm on overflow. Other behaviour can only be shown by the bench's scenarios. These are: the exact cycle at which each edge appears for a given dead-time, the two-edge break latency, the flag clear being refused and later accepted, the drive-enable selection, and that a disabled or wrong-polarity pin changes nothing.

// File: rtl/pbk_pkg.sv
// Shared definitions for the complementary PWM break stage.
package pbk_pkg;
    // Default width of the dead-time count in timer clocks.
    localparam int DT_W_DEF = 8;

    // Main/complementary pair as produced by the dead-time generator.
    typedef struct packed {
        logic main;
        logic comp;
    } pair_t;
endpackage

// File: rtl/pbk_brk_sync.sv
// Break qualifier and synchronizer.
// Applies the polarity and the enable to the raw pin, then passes the result
// through STAGES flops. Assumes STAGES >= 2. The outputs are the first stage
// (early), the last stage (sync) and the OR of all stages (any).
module pbk_brk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_i,
    input  logic brk_en,
    input  logic brk_pol,
    output logic brk_early,
    output logic brk_sync,
    output logic brk_any
);
    localparam int LAST = STAGES - 1;

    logic              act;
    logic [STAGES-1:0] chain;

    // Qualify the pin with its enable and active level.
    always_comb act = brk_en & (brk_i == brk_pol);

    // Shift the qualified break through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= act;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign brk_early = chain[0];
    assign brk_sync  = chain[LAST];
    assign brk_any   = |chain;
endmodule

// File: rtl/pbk_deadtime.sv
// Dead-time generator.
// Registers the reference. Every change reloads a down-counter with the
// dead-time. Both outputs stay low while the counter is non-zero, so only
// rising edges are delayed. Assumes dt is stable or changes at will; a new
// value takes effect at the next reference change.
module pbk_deadtime
    import pbk_pkg::*;
#(
    parameter int DT_W = DT_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_i,
    input  logic [DT_W-1:0] dt,
    output pair_t           pwm
);
    logic            ref_q;
    logic [DT_W-1:0] cnt;
    logic            settled;

    // Track the reference and count the gap after each change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= 1'b0;
            cnt   <= '0;
        end else begin
            ref_q <= ref_i;
            if (ref_i != ref_q) begin
                cnt <= dt;
            end else if (cnt != '0) begin
                cnt <= cnt - DT_W'(1);
            end
        end
    end

    // Drive the pair once the gap has elapsed.
    always_comb begin
        settled  = (cnt == '0);
        pwm.main = settled & ref_q;
        pwm.comp = settled & ~ref_q;
    end
endmodule

// File: rtl/pbk_oe_ctrl.sv
// Output-enable and break-flag control.
// Holds the global output-enable bit and the sticky break flag. The first
// sync stage locks output enable off. The last stage sets the flag. Any
// stage blocks a flag clear. Also reports the edge where output enable drops.
module pbk_oe_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_early,
    input  logic brk_sync,
    input  logic brk_any,
    input  logic sw_oe_set,
    input  logic sw_oe_clr,
    input  logic sw_flag_clr,
    input  logic auto_oe,
    input  logic ovf_i,
    output logic oe,
    output logic oe_fall,
    output logic flag
);
    logic oe_q;
    logic oe_next;

    // Resolve the output-enable request by priority.
    always_comb begin
        if (brk_early)              oe_next = 1'b0;
        else if (sw_oe_set)         oe_next = 1'b1;
        else if (sw_oe_clr)         oe_next = 1'b0;
        else if (auto_oe && ovf_i)  oe_next = 1'b1;
        else                        oe_next = oe_q;
    end

    // Register the output enable.
    always_ff @(posedge clk) begin
        if (!rst_n) oe_q <= 1'b0;
        else        oe_q <= oe_next;
    end

    // Set the flag on a synchronized break; clear it only once break is gone.
    always_ff @(posedge clk) begin
        if (!rst_n)                       flag <= 1'b0;
        else if (brk_sync)                flag <= 1'b1;
        else if (sw_flag_clr && !brk_any) flag <= 1'b0;
    end

    assign oe      = oe_q;
    assign oe_fall = oe_q & ~oe_next;

    // R7
    oe_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_early |=> !oe);

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_sync |=> flag);

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && brk_any) |=> flag);

    // R8
    auto_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_oe && ovf_i && !brk_early && !sw_oe_clr) |=> oe);
endmodule

// File: rtl/pbk_out_stage.sv
// Output multiplexer with off-state entry gap.
// While output enable is set, it passes the dead-time pair. When output enable
// drops, it holds both outputs low for the dead-time, then shows the idle
// levels. It also selects the drive enables for the on and off states.
module pbk_out_stage
    import pbk_pkg::*;
#(
    parameter int DT_W = DT_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            oe,
    input  logic            oe_fall,
    input  logic [DT_W-1:0] dt,
    input  pair_t           pwm,
    input  logic            idle_main,
    input  logic            idle_comp,
    input  logic            ch_en,
    input  logic            chn_en,
    input  logic            keep_en,
    output logic            out_main,
    output logic            out_comp,
    output logic            oen_main,
    output logic            oen_comp
);
    logic [DT_W-1:0] icnt;

    // Count the low gap on entry to the off state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            icnt <= '0;
        end else if (oe_fall) begin
            icnt <= dt;
        end else if (icnt != '0) begin
            icnt <= icnt - DT_W'(1);
        end
    end

    // Select output levels for the on, gap and idle states.
    always_comb begin
        if (oe) begin
            out_main = pwm.main;
            out_comp = pwm.comp;
        end else if (icnt != '0) begin
            out_main = 1'b0;
            out_comp = 1'b0;
        end else begin
            out_main = idle_main;
            out_comp = idle_comp;
        end
    end

    // Select the drive enables for the on state and the off state.
    always_comb begin
        if (oe) begin
            oen_main = ch_en;
            oen_comp = chn_en;
        end else if (keep_en) begin
            oen_main = ch_en | chn_en;
            oen_comp = ch_en | chn_en;
        end else begin
            oen_main = 1'b0;
            oen_comp = 1'b0;
        end
    end

    // R4
    idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_fall && dt != '0) |=> (!out_main && !out_comp));
endmodule

// File: rtl/pwm_brk_stage.sv
// Complementary PWM output stage with break handling (top).
// Connects the break synchronizer, the output-enable control, the dead-time
// generator and the output multiplexer. Assumes ovf_i is a one-cycle pulse
// and that the software request inputs are one-cycle write strobes.
module pwm_brk_stage
    import pbk_pkg::*;
#(
    parameter int DT_W        = DT_W_DEF,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_i,
    input  logic            ovf_i,
    input  logic            brk_i,
    input  logic            brk_en,
    input  logic            brk_pol,
    input  logic [DT_W-1:0] dt_cnt,
    input  logic            idle_main,
    input  logic            idle_comp,
    input  logic            ch_en,
    input  logic            chn_en,
    input  logic            keep_en,
    input  logic            auto_oe,
    input  logic            brk_ie,
    input  logic            sw_oe_set,
    input  logic            sw_oe_clr,
    input  logic            sw_flag_clr,
    output logic            out_main,
    output logic            out_comp,
    output logic            oen_main,
    output logic            oen_comp,
    output logic            oe,
    output logic            brk_flag,
    output logic            irq
);
    logic  brk_early;
    logic  brk_sync;
    logic  brk_any;
    logic  oe_fall;
    pair_t pwm;

    pbk_brk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .brk_i     (brk_i),
        .brk_en    (brk_en),
        .brk_pol   (brk_pol),
        .brk_early (brk_early),
        .brk_sync  (brk_sync),
        .brk_any   (brk_any)
    );

    pbk_oe_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .brk_early   (brk_early),
        .brk_sync    (brk_sync),
        .brk_any     (brk_any),
        .sw_oe_set   (sw_oe_set),
        .sw_oe_clr   (sw_oe_clr),
        .sw_flag_clr (sw_flag_clr),
        .auto_oe     (auto_oe),
        .ovf_i       (ovf_i),
        .oe          (oe),
        .oe_fall     (oe_fall),
        .flag        (brk_flag)
    );

    pbk_deadtime #(.DT_W(DT_W)) u_dt (
        .clk   (clk),
        .rst_n (rst_n),
        .ref_i (ref_i),
        .dt    (dt_cnt),
        .pwm   (pwm)
    );

    pbk_out_stage #(.DT_W(DT_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .oe        (oe),
        .oe_fall   (oe_fall),
        .dt        (dt_cnt),
        .pwm       (pwm),
        .idle_main (idle_main),
        .idle_comp (idle_comp),
        .ch_en     (ch_en),
        .chn_en    (chn_en),
        .keep_en   (keep_en),
        .out_main  (out_main),
        .out_comp  (out_comp),
        .oen_main  (oen_main),
        .oen_comp  (oen_comp)
    );

    // Level interrupt request from the flag and its enable.
    assign irq = brk_flag & brk_ie;

    // R2
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> !(out_main && out_comp));
endmodule

// File: tb/pwm_brk_stage_tb.sv
// Self-checking bench: directed corner cases followed by seeded random
// stimulus, compared every cycle against a bench-side reference model.
module pwm_brk_stage_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_i = 0, ovf_i = 0, brk_i = 0, brk_en = 0, brk_pol = 1;
    logic [7:0] dt_cnt = 8'd0;
    logic       idle_main = 0, idle_comp = 0, ch_en = 0, chn_en = 0, keep_en = 0;
    logic       auto_oe = 0, brk_ie = 0, sw_oe_set = 0, sw_oe_clr = 0, sw_flag_clr = 0;
    logic       out_main, out_comp, oen_main, oen_comp, oe, brk_flag, irq;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    // model state
    bit m_s1, m_s2, m_oe, m_flag, m_refq;
    int m_cnt, m_icnt;

    pwm_brk_stage u_dut (
        .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .ovf_i(ovf_i), .brk_i(brk_i),
        .brk_en(brk_en), .brk_pol(brk_pol), .dt_cnt(dt_cnt),
        .idle_main(idle_main), .idle_comp(idle_comp), .ch_en(ch_en),
        .chn_en(chn_en), .keep_en(keep_en), .auto_oe(auto_oe), .brk_ie(brk_ie),
        .sw_oe_set(sw_oe_set), .sw_oe_clr(sw_oe_clr), .sw_flag_clr(sw_flag_clr),
        .out_main(out_main), .out_comp(out_comp), .oen_main(oen_main),
        .oen_comp(oen_comp), .oe(oe), .brk_flag(brk_flag), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Expected output levels {main, comp} from model state.
    function automatic logic [1:0] exp_out();
        bit pm, pc;
        pm = (m_cnt == 0) && m_refq;
        pc = (m_cnt == 0) && !m_refq;
        if (m_oe)            return {pm, pc};
        else if (m_icnt != 0) return 2'b00;
        else                 return {idle_main, idle_comp};
    endfunction

    // Expected drive enables {main, comp}.
    function automatic logic [1:0] exp_oen();
        if (m_oe)         return {ch_en, chn_en};
        else if (keep_en) return {2{ch_en | chn_en}};
        else              return 2'b00;
    endfunction

    // Reference model, advanced at each clock edge from the requirements.
    always @(posedge clk) begin
        bit act, oe_n;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_oe = 0; m_flag = 0; m_refq = 0;
            m_cnt = 0; m_icnt = 0;
        end else begin
            act = brk_en && (brk_i == brk_pol);
            if (m_s1)                   oe_n = 0;
            else if (sw_oe_set)         oe_n = 1;
            else if (sw_oe_clr)         oe_n = 0;
            else if (auto_oe && ovf_i)  oe_n = 1;
            else                        oe_n = m_oe;
            if (m_oe && !oe_n)    m_icnt = dt_cnt;
            else if (m_icnt != 0) m_icnt--;
            m_oe = oe_n;
            if (m_s2)                             m_flag = 1;
            else if (sw_flag_clr && !(m_s1 || m_s2)) m_flag = 0;
            if (ref_i != m_refq)  m_cnt = dt_cnt;
            else if (m_cnt != 0)  m_cnt--;
            m_refq = ref_i;
            m_s2 = m_s1;
            m_s1 = act;
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [1:0] eo, ee;
            eo = exp_out();
            ee = exp_oen();
            if (m_oe) chk({out_main, out_comp} == eo, "R1 levels", {out_main, out_comp}, eo);
            else      chk({out_main, out_comp} == eo, "R4 levels", {out_main, out_comp}, eo);
            if (oe)   chk(!(out_main && out_comp), "R2 overlap", {out_main, out_comp}, 0);
            chk({oen_main, oen_comp} == ee, "R9 enables", {oen_main, oen_comp}, ee);
            chk(oe == m_oe, "R3 oe", oe, m_oe);
            chk(brk_flag == m_flag, "R5 flag", brk_flag, m_flag);
            chk(irq == (m_flag && brk_ie), "R10 irq", irq, m_flag && brk_ie);
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'h5EED_0425));
        // R11: reset state
        repeat (4) step();
        chk(oe == 0, "R11 oe", oe, 0);
        chk(brk_flag == 0, "R11 flag", brk_flag, 0);
        chk({out_main, out_comp} == 2'b00, "R11 outs", {out_main, out_comp}, 0);
        chk({oen_main, oen_comp} == 2'b00, "R11 oen", {oen_main, oen_comp}, 0);
        rst_n = 1;
        brk_en = 1; brk_pol = 1; dt_cnt = 8'd3; ch_en = 1; chn_en = 1; brk_ie = 1;
        sw_oe_set = 1; step(); sw_oe_set = 0;
        chk(oe == 1, "R7 set", oe, 1);
        repeat (5) step();
        // R1: rising edge delayed by dt, complement drops at once
        ref_i = 1;
        n = 0;
        step(); n++;
        chk(out_comp == 0, "R1 comp fall", out_comp, 0);
        while (!out_main && n < 20) begin step(); n++; end
        chk(n == 4, "R1 delay", n, 4);
        repeat (6) step();
        // R3: break reaches oe after two edges
        brk_i = 1;
        step();
        chk(oe == 1, "R3 first edge", oe, 1);
        step();
        chk(oe == 0, "R3 second edge", oe, 0);
        chk({out_main, out_comp} == 2'b00, "R4 gap", {out_main, out_comp}, 0);
        // R6 and R7: clear and set refused while break is held
        sw_oe_set = 1; sw_flag_clr = 1;
        repeat (4) step();
        sw_oe_set = 0; sw_flag_clr = 0;
        chk(oe == 0, "R7 locked", oe, 0);
        chk(brk_flag == 1, "R6 locked", brk_flag, 1);
        chk(irq == 1, "R10 raised", irq, 1);
        brk_i = 0;
        repeat (3) step();
        sw_flag_clr = 1; step(); sw_flag_clr = 0;
        chk(brk_flag == 0, "R6 cleared", brk_flag, 0);
        chk(irq == 0, "R10 dropped", irq, 0);
        // R8: automatic re-arm on overflow
        auto_oe = 1; ovf_i = 1; step(); ovf_i = 0;
        chk(oe == 1, "R8 rearm", oe, 1);
        // R3: disabled detection and wrong polarity have no effect
        brk_en = 0; brk_i = 1;
        repeat (4) step();
        chk(oe == 1, "R3 disabled", oe, 1);
        brk_en = 1; brk_pol = 0;
        repeat (4) step();
        chk(oe == 1, "R3 polarity", oe, 1);
        chk(brk_flag == 0, "R5 no flag", brk_flag, 0);
        brk_pol = 1; brk_i = 0;
        // Random phase, checked cycle by cycle by the model
        for (int cyc = 0; cyc < 6000; cyc++) begin
            if (cyc % 500 == 0) begin
                dt_cnt    = 8'($urandom_range(0, 6));
                idle_main = 1'($urandom);
                idle_comp = 1'($urandom);
                auto_oe   = 1'($urandom);
                brk_pol   = 1'($urandom);
            end
            if (cyc % 200 == 0) begin
                ch_en   = 1'($urandom);
                chn_en  = 1'($urandom);
                keep_en = 1'($urandom);
                brk_ie  = 1'($urandom);
                brk_en  = ($urandom_range(0, 7) != 0);
            end
            if ($urandom_range(0, 5) == 0)  ref_i = ~ref_i;
            if ($urandom_range(0, 79) == 0) brk_i = ~brk_i;
            ovf_i       = ($urandom_range(0, 19) == 0);
            sw_oe_set   = ($urandom_range(0, 29) == 0);
            sw_oe_clr   = ($urandom_range(0, 59) == 0);
            sw_flag_clr = ($urandom_range(0, 29) == 0);
            step();
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule